// File: doc/BRIEF.md
# Companion-Chip System Control Register File

This block is the system control register space of a peripheral companion chip. A host reaches it one byte at a time through a simple bus with an 8-bit offset. Each request is a single-cycle strobe with a write flag, and every offset is its own byte register. The space holds four kinds of register:

- a fixed revision code;
- an interrupt status, mask and routing trio, with the status driven by eight peripheral interrupt lines;
- the output data and output-enable registers of a 16-pin general-purpose output port;
- plain storage bytes for clock, PLL, pin-control, function-enable and mode settings.

The block drives one combined interrupt request. It also drives each pin's effective output level, together with a one-cycle strobe that marks the pins whose level has just changed. The bus never stalls. A request is accepted on the clock edge where `bus_en` is high, so the port has no back-pressure and no ready signal. Read data is registered and appears after that edge. It holds its value until the next read. Software may overwrite the interrupt status. A later change on a peripheral line sets or clears that line's bit again, so the bit tracks the line.

Top module: `sysctl_regs`

## Requirements
- R1: Reading offset 0x08 returns 3 and reading offset 0x09 returns 0. Read data is valid after the clock edge that accepts the read, and it holds until the next read.
- R2: Offsets 0x50 (interrupt status), 0x52 (interrupt mask) and 0x54 (interrupt routing) are read/write bytes. A register keeps its value when no write is made to it.
- R3: When interrupt line n (bit n of `irq_lines`) changes level, status bit n takes the new level at the next clock edge. This holds even if software writes the status register in the same cycle. Bits whose line did not change take the written value.
- R4: `irq_o` is high exactly when status AND mask is nonzero. It follows the registers in the same cycle.
- R5: Output data is at offsets 0x78 to 0x7A and output enable is at 0x7C to 0x7E. Byte lane n of each holds bits 8n to 8n+7. All 24 bits of each register read back as written, including bits 16 to 23, which drive no pin.
- R6: `gpio_level` equals output data AND output enable, bits 0 to 15. It updates at the edge that accepts the write.
- R7: `gpio_strobe` bit n is high for exactly one cycle, after a write that changes the effective level of pin n. It stays low when a write leaves the effective level unchanged.
- R8: The 16-bit registers at 0x60, 0x8C, 0x90, 0x94, 0x98, 0x9A and 0xE4, the 32-bit register at 0x9C and the byte at 0xE0 are plain little-endian storage. Each byte lane is written alone, and the other lanes keep their values.
- R9: The three-byte arrays at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88 give each of their three offsets its own read/write byte.
- R10: A read of an unmapped offset returns 0, and a write to it, or to 0x08 or 0x09, changes nothing. Each such access raises `bus_err` for the one cycle after the edge that accepts it.
- R11: After reset every register is 0, the read data is 0, `gpio_level` and `gpio_strobe` are 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request, accepted on the clock edge where it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an access to an unmapped offset |
| irq_lines | input | 8 | Peripheral interrupt line levels |
| irq_o | output | 1 | Combined interrupt request |
| gpio_level | output | 16 | Effective pin output levels |
| gpio_strobe | output | 16 | One-cycle change marker per pin |

## Verification
Each result is due after exactly one clock edge. For a read, the data and the error pulse appear after the edge that accepts the request. Pin levels and strobes move on the edge that accepts a write. A status bit, and through it `irq_o`, follows a line change on the first edge that sees it. The bench drives every input on a falling edge and advances its reference model at the next rising edge. It compares all outputs at the falling edge after that, so every check lands exactly one register stage after its stimulus.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_REV_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_REV_HI = 8'h09;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h52;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_GDATA  = 8'h78;
  localparam logic [ADDR_W-1:0] OFS_GOE    = 8'h7C;
  localparam logic [BYTE_W-1:0] REV_VALUE  = 8'd3;

  // Plain storage groups: base offset and byte count
  localparam int N_GRP = 16;
  localparam logic [ADDR_W-1:0] GRP_BASE [N_GRP] = '{
    8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h80, 8'h84, 8'h88,
    8'h8C, 8'h90, 8'h94, 8'h98, 8'h9A, 8'h9C, 8'hE0, 8'hE4};
  localparam int GRP_LEN [N_GRP] = '{
    2, 3, 3, 3, 3, 3, 3, 3,
    2, 2, 2, 2, 2, 4, 1, 2};

  function automatic int grp_total();
    int s;
    s = 0;
    for (int g = 0; g < N_GRP; g++) s += GRP_LEN[g];
    return s;
  endfunction

  localparam int N_STORE = grp_total();

  function automatic logic store_hit(input logic [ADDR_W-1:0] a);
    logic h;
    h = 1'b0;
    for (int g = 0; g < N_GRP; g++)
      if (int'(a) >= int'(GRP_BASE[g]) && int'(a) < int'(GRP_BASE[g]) + GRP_LEN[g])
        h = 1'b1;
    return h;
  endfunction

  function automatic int store_slot(input logic [ADDR_W-1:0] a);
    int acc, idx;
    acc = 0;
    idx = 0;
    for (int g = 0; g < N_GRP; g++) begin
      if (int'(a) >= int'(GRP_BASE[g]) && int'(a) < int'(GRP_BASE[g]) + GRP_LEN[g])
        idx = acc + int'(a) - int'(GRP_BASE[g]);
      acc += GRP_LEN[g];
    end
    return idx;
  endfunction
endpackage

// File: rtl/sysctl_irq.sv
module sysctl_irq
  import sysctl_pkg::*;
#(
  parameter int N_LINE = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [N_LINE-1:0] line_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_LINE-1:0] stat_q, mask_q, route_q, line_q;
  logic [N_LINE-1:0] stat_sw, delta, stat_d;

  always_comb begin
    stat_sw = (wr_i && addr_i == OFS_STAT) ? wdata_i[N_LINE-1:0] : stat_q;
    delta   = line_i ^ line_q;
    stat_d  = (stat_sw & ~delta) | (line_i & delta);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
      line_q  <= '0;
    end else begin
      stat_q <= stat_d;
      line_q <= line_i;
      if (wr_i && addr_i == OFS_MASK)  mask_q  <= wdata_i[N_LINE-1:0];
      if (wr_i && addr_i == OFS_ROUTE) route_q <= wdata_i[N_LINE-1:0];
    end
  end

  assign irq_o = |(stat_q & mask_q);

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (addr_i)
      OFS_STAT:  rdata_o = BYTE_W'(stat_q);
      OFS_MASK:  rdata_o = BYTE_W'(mask_q);
      OFS_ROUTE: rdata_o = BYTE_W'(route_q);
      default:   hit_o   = 1'b0;
    endcase
  end

  // R3
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i != line_q) |=> ((stat_q & $past(line_i ^ line_q)) == ($past(line_i) & $past(line_i ^ line_q))));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == OFS_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio
  import sysctl_pkg::*;
#(
  parameter int N_PIN = 16,
  parameter int LANES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [N_PIN-1:0]  level_o,
  output logic [N_PIN-1:0]  strobe_o
);
  localparam int REG_W = LANES * BYTE_W;

  logic [REG_W-1:0] data_q, oe_q, data_d, oe_d;
  logic [N_PIN-1:0] eff_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [ADDR_W-1:0] D_OFS = ADDR_W'(int'(OFS_GDATA) + l);
    localparam logic [ADDR_W-1:0] E_OFS = ADDR_W'(int'(OFS_GOE) + l);
    assign data_d[l*BYTE_W +: BYTE_W] = (wr_i && addr_i == D_OFS) ? wdata_i : data_q[l*BYTE_W +: BYTE_W];
    assign oe_d[l*BYTE_W +: BYTE_W]   = (wr_i && addr_i == E_OFS) ? wdata_i : oe_q[l*BYTE_W +: BYTE_W];
  end

  assign eff_d = data_d[N_PIN-1:0] & oe_d[N_PIN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      oe_q     <= '0;
      level_o  <= '0;
      strobe_o <= '0;
    end else begin
      data_q   <= data_d;
      oe_q     <= oe_d;
      level_o  <= eff_d;
      strobe_o <= eff_d ^ level_o;
    end
  end

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (addr_i == ADDR_W'(int'(OFS_GDATA) + l)) begin
        hit_o   = 1'b1;
        rdata_o = data_q[l*BYTE_W +: BYTE_W];
      end
      if (addr_i == ADDR_W'(int'(OFS_GOE) + l)) begin
        hit_o   = 1'b1;
        rdata_o = oe_q[l*BYTE_W +: BYTE_W];
      end
    end
  end

  // R6
  gpio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o & ~oe_q[N_PIN-1:0]) == '0);

  // R7
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 strobe_o == (level_o ^ $past(level_o)));
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int N_BYTE = N_STORE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(N_BYTE);

  logic [BYTE_W-1:0] mem_q [N_BYTE];
  logic [IDX_W-1:0]  sidx;

  assign hit_o = store_hit(addr_i);
  assign sidx  = IDX_W'(store_slot(addr_i));

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                                       mem_q[i] <= '0;
      else if (wr_i && hit_o && sidx == IDX_W'(i))      mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = hit_o ? mem_q[sidx] : '0;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_GPIO = 16,
  parameter int G_LANE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic [N_IRQ-1:0]  irq_lines,
  output logic              irq_o,
  output logic [N_GPIO-1:0] gpio_level,
  output logic [N_GPIO-1:0] gpio_strobe
);
  logic wr;
  logic irq_hit, gp_hit, st_hit, rev_hit, rw_hit, rd_hit;
  logic [BYTE_W-1:0] irq_rd, gp_rd, st_rd, rev_rd, rd_mux;

  assign wr = bus_en && bus_we;

  sysctl_irq #(.N_LINE(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .line_i(irq_lines), .hit_o(irq_hit), .rdata_o(irq_rd), .irq_o(irq_o));

  sysctl_gpio #(.N_PIN(N_GPIO), .LANES(G_LANE)) u_gpio (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .hit_o(gp_hit), .rdata_o(gp_rd), .level_o(gpio_level), .strobe_o(gpio_strobe));

  sysctl_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .hit_o(st_hit), .rdata_o(st_rd));

  always_comb begin
    rev_hit = 1'b1;
    rev_rd  = '0;
    case (bus_addr)
      OFS_REV_LO: rev_rd  = REV_VALUE;
      OFS_REV_HI: rev_rd  = '0;
      default:    rev_hit = 1'b0;
    endcase
  end

  assign rw_hit = irq_hit | gp_hit | st_hit;
  assign rd_hit = rw_hit | rev_hit;
  assign rd_mux = irq_rd | gp_rd | st_rd | rev_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bus_en && (bus_we ? !rw_hit : !rd_hit);
      if (bus_en && !bus_we) bus_rdata <= rd_hit ? rd_mux : '0;
    end
  end

  // R10
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !rd_hit) |=> (bus_err && bus_rdata == '0));
endmodule

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_err;
  logic [7:0] irq_lines = '0;
  logic irq_o;
  logic [15:0] gpio_level, gpio_strobe;

  always #5 clk = ~clk;

  sysctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_lines(irq_lines), .irq_o(irq_o), .gpio_level(gpio_level), .gpio_strobe(gpio_strobe));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0]  mdl [256];
  logic [7:0]  m_lines_prev;
  logic [15:0] m_eff_prev;
  logic [7:0]  m_rdata;

  function automatic bit in_store(int a);
    return (a >= 'h60 && a <= 'h61) || (a >= 'h64 && a <= 'h66) || (a >= 'h68 && a <= 'h6A) ||
           (a >= 'h6C && a <= 'h6E) || (a >= 'h70 && a <= 'h72) || (a >= 'h80 && a <= 'h82) ||
           (a >= 'h84 && a <= 'h86) || (a >= 'h88 && a <= 'h8A) || (a >= 'h8C && a <= 'h8D) ||
           (a >= 'h90 && a <= 'h91) || (a >= 'h94 && a <= 'h95) || (a >= 'h98 && a <= 'h9F) ||
           a == 'hE0 || a == 'hE4 || a == 'hE5;
  endfunction

  function automatic bit is_rw(int a);
    return in_store(a) || a == 'h50 || a == 'h52 || a == 'h54 ||
           (a >= 'h78 && a <= 'h7A) || (a >= 'h7C && a <= 'h7E);
  endfunction

  function automatic bit is_rd(int a);
    return is_rw(a) || a == 'h08 || a == 'h09;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    if (a == 'h08) return 8'd3;
    if (a == 'h09) return 8'd0;
    if (is_rw(a)) return mdl[a];
    return 8'd0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 'h08 || a == 'h09) return "R1";
    if (a == 'h50) return "R3";
    if (a == 'h52 || a == 'h54) return "R2";
    if ((a >= 'h78 && a <= 'h7A) || (a >= 'h7C && a <= 'h7E)) return "R5";
    if ((a >= 'h64 && a <= 'h72) || (a >= 'h80 && a <= 'h8A)) return "R9";
    if (in_store(a)) return "R8";
    return "R10";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit we, int a, logic [7:0] d, logic [7:0] lines);
    logic [7:0] ld;
    logic [15:0] eff;
    bit exp_err;
    string t;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a[7:0]; bus_wdata = d; irq_lines = lines;
    @(posedge clk);
    t = tag_of(a);
    exp_err = en && (we ? !is_rw(a) : !is_rd(a));
    if (en && !we) m_rdata = exp_read(a);
    if (en && we && is_rw(a)) mdl[a] = d;
    ld = lines ^ m_lines_prev;
    mdl['h50] = (mdl['h50] & ~ld) | (lines & ld);
    m_lines_prev = lines;
    eff = {mdl['h79], mdl['h78]} & {mdl['h7D], mdl['h7C]};
    @(negedge clk);
    bus_en = 1'b0;
    if (en && !we) chk(t, "read data", bus_rdata, m_rdata);
    chk("R10", "error pulse", bus_err, exp_err);
    chk("R4", "irq", irq_o, |(mdl['h50] & mdl['h52]));
    chk("R6", "gpio level", gpio_level, eff);
    chk("R7", "gpio strobe", gpio_strobe, eff ^ m_eff_prev);
    m_eff_prev = eff;
  endtask

  task automatic rd(int a); step(1, 0, a, 8'h00, irq_lines); endtask
  task automatic wrb(int a, logic [7:0] d); step(1, 1, a, d, irq_lines); endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pick [24] = '{'h08,'h09,'h50,'h52,'h54,'h60,'h61,'h66,'h6C,'h88,'h8A,'h8C,
                      'h9C,'h9D,'h9E,'h9F,'hE0,'hE5,'h78,'h79,'h7A,'h7C,'h7D,'h7E};
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    m_lines_prev = '0; m_eff_prev = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", "rdata", bus_rdata, 8'h00);
    chk("R11", "err", bus_err, 1'b0);
    chk("R11", "irq", irq_o, 1'b0);
    chk("R11", "gpio level", gpio_level, 16'h0);
    chk("R11", "gpio strobe", gpio_strobe, 16'h0);
    rd('h50); rd('h7C); rd('h9C);
    // R1 revision
    rd('h08); rd('h09);
    // R10 write to read-only and unmapped
    wrb('h08, 8'hAA); rd('h08);
    wrb('h30, 8'h55); rd('h30); rd('hFF);
    // R8 lane independence on the 32-bit register
    wrb('h9C, 8'h11); wrb('h9D, 8'h22); wrb('h9E, 8'h33); wrb('h9F, 8'h44);
    wrb('h9D, 8'hEE); rd('h9C); rd('h9D); rd('h9E); rd('h9F);
    // R9 array entries
    wrb('h88, 8'h01); wrb('h8A, 8'h03); rd('h88); rd('h89); rd('h8A);
    // R7 data change with output enable off: no strobe
    wrb('h78, 8'hFF);
    wrb('h7C, 8'h0F);
    wrb('h7E, 8'hFF); wrb('h7A, 8'hFF); rd('h7A);
    wrb('h78, 8'hFF);
    // R3/R4 line tracking and software overwrite
    wrb('h52, 8'h05);
    step(0, 0, 0, 8'h00, 8'h01);
    wrb('h50, 8'h00);
    step(0, 0, 0, 8'h00, 8'h05);
    step(1, 1, 'h50, 8'hFF, 8'h01);
    rd('h50);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] ln;
      int a;
      ln = irq_lines;
      if ($urandom % 4 == 0) ln = ln ^ (8'h01 << ($urandom % 8));
      a = ($urandom % 10 < 7) ? pick[$urandom % 24] : int'($urandom % 256);
      step($urandom % 5 != 0, $urandom % 2 == 0, a, 8'($urandom), ln);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule